// File: doc/BRIEF.md
# Map Register Write-Unlock Sequencer

This block watches a stream of single-cycle write operations, each carrying a 12-bit offset, a 4-bit page field, and a byte of data. It looks for a fixed five-step command handshake. When that handshake completes, it accepts one more write whose byte becomes the new contents of one of two map registers. The register storage itself lives outside the block. The sequencer gives that storage a one-clock load strobe per register and the value to load.

Once the value write is taken, the sequencer holds `busy` high for a programmable number of clocks, which stands for the write-cycle time. It ignores all bus traffic during that time and then returns to idle. A write that does not match the step the sequencer expects abandons the handshake without loading anything.

Command writes count only when their page field equals the expected page. The expected page has the current memory-map page bits (three bits) as its upper bits. Its lowest bit is the inverse of the plane-select bit of the plane currently being read.

States:
- `ST_IDLE`: waiting for the first command.
- `ST_STEP1`, `ST_STEP2`, `ST_STEP3`, `ST_STEP4`: one, two, three or four commands matched.
- `ST_ARM_SFR`, `ST_ARM_MEM`: selector matched; waiting for the value write.
- `ST_WAIT`: write-cycle time running.

Transitions:
- `ST_IDLE` goes to `ST_STEP1` on a matching first command.
- Each step state advances on a matching command and falls back to `ST_IDLE` on any other write.
- `ST_STEP4` goes to `ST_ARM_SFR` on selector 0xD0 and to `ST_ARM_MEM` on selector 0xE0.
- Either arm state goes to `ST_WAIT` on any write.
- `ST_WAIT` goes to `ST_IDLE` when the timer reaches its last cycle.

Top module: `ulk_seq`

## Requirements
- R1: After reset, `ld_sfr`, `ld_mem` and `busy` are low and the sequencer is idle.
- R2: The writes (offset/data) 0x555/0xAA, 0xAAA/0x55, 0x555/0xA0, 0x555/0xAA and 0x555/0xD0, followed by one more write, pulse `ld_sfr`. With selector 0xE0 in place of 0xD0, the same sequence pulses `ld_mem`.
- R3: A command write is accepted only when `wr_page` equals {`map_page`[2:0], ~`rd_plane`}, with `map_page` in bits 3:1 and the inverted plane bit in bit 0. A command write on any other page aborts the handshake.
- R4: A write whose offset, data or selector differs from the expected step returns the sequencer to idle with no load. A complete sequence issued afterwards succeeds.
- R5: The value write's offset and page are ignored. `ld_value` equals that write's data while the load strobe is high.
- R6: A load strobe is high for exactly one clock, in the cycle after the value write's clock edge, and the two strobes are never high together.
- R7: `busy` rises together with the load strobe and stays high for exactly `WC_CYCLES` consecutive clocks.
- R8: Writes made while `busy` is high have no effect. A full handshake issued during that time produces no load, and a handshake issued after `busy` falls succeeds.
- R9: While `wr_en` is low, values on the bus are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 12 | Write offset within the page |
| wr_page | input | 4 | Upper address bits of the write |
| wr_data | input | 8 | Write data |
| map_page | input | 3 | Current memory-map page bits |
| rd_plane | input | 1 | Plane-select bit of the plane being read |
| ld_sfr | output | 1 | Load strobe, special-function map register |
| ld_mem | output | 1 | Load strobe, memory map register |
| ld_value | output | 8 | Value to load |
| busy | output | 1 | Write-cycle time in progress |

## Verification
The assertions assume that `wr_en` is a clean single-cycle strobe sampled on the rising edge. They also assume that `map_page` and `rd_plane` do not change while a handshake is in progress.

The bench drives every input at the falling edge and raises `wr_en` for one cycle per write. It sets the page inputs only between handshakes. It leaves enough idle clocks for `busy` to drain, except in the test that deliberately writes during `busy`.

// File: rtl/ulk_pkg.sv
package ulk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP1,
        ST_STEP2,
        ST_STEP3,
        ST_STEP4,
        ST_ARM_SFR,
        ST_ARM_MEM,
        ST_WAIT
    } ulk_state_t;

    localparam logic [11:0] OFS_LO   = 12'h555;
    localparam logic [11:0] OFS_HI   = 12'hAAA;
    localparam logic [7:0]  KEY_A    = 8'hAA;
    localparam logic [7:0]  KEY_B    = 8'h55;
    localparam logic [7:0]  KEY_C    = 8'hA0;
    localparam logic [7:0]  SEL_SFR  = 8'hD0;
    localparam logic [7:0]  SEL_MEM  = 8'hE0;

    typedef struct packed {
        logic key_a;
        logic key_b;
        logic key_c;
        logic sel_sfr;
        logic sel_mem;
    } ulk_hits_t;

endpackage

// File: rtl/ulk_page_chk.sv
module ulk_page_chk #(
    parameter int PAGE_W = 4,
    localparam int MAP_W = PAGE_W - 1
) (
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [MAP_W-1:0]  map_page,
    input  logic              rd_plane,
    output logic              page_ok
);
    logic [PAGE_W-1:0] want_page;

    always_comb begin
        want_page = {map_page, ~rd_plane};
        page_ok   = (wr_page == want_page);
    end
endmodule

// File: rtl/ulk_step_match.sv
module ulk_step_match
    import ulk_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              page_ok,
    output ulk_hits_t         hits
);
    logic at_lo;
    logic at_hi;

    always_comb begin
        at_lo        = page_ok && (wr_addr == ADDR_W'(OFS_LO));
        at_hi        = page_ok && (wr_addr == ADDR_W'(OFS_HI));
        hits.key_a   = at_lo && (wr_data == DATA_W'(KEY_A));
        hits.key_b   = at_hi && (wr_data == DATA_W'(KEY_B));
        hits.key_c   = at_lo && (wr_data == DATA_W'(KEY_C));
        hits.sel_sfr = at_lo && (wr_data == DATA_W'(SEL_SFR));
        hits.sel_mem = at_lo && (wr_data == DATA_W'(SEL_MEM));
    end
endmodule

// File: rtl/ulk_wc_timer.sv
module ulk_wc_timer #(
    parameter int WC_CYCLES = 64,
    localparam int CNT_W = $clog2(WC_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic last
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= CNT_W'(WC_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    always_comb begin
        busy = (remain != '0);
        last = (remain == CNT_W'(1));
    end
endmodule

// File: rtl/ulk_seq.sv
module ulk_seq
    import ulk_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    parameter int PAGE_W    = 4,
    parameter int WC_CYCLES = 64,
    localparam int MAP_W    = PAGE_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [MAP_W-1:0]  map_page,
    input  logic              rd_plane,
    output logic              ld_sfr,
    output logic              ld_mem,
    output logic [DATA_W-1:0] ld_value,
    output logic              busy
);
    ulk_state_t state_q;
    ulk_state_t state_d;
    ulk_hits_t  hits;
    logic       page_ok;
    logic       tmr_start;
    logic       tmr_last;
    logic       take_value;

    ulk_page_chk #(.PAGE_W(PAGE_W)) u_page (
        .wr_page  (wr_page),
        .map_page (map_page),
        .rd_plane (rd_plane),
        .page_ok  (page_ok)
    );

    ulk_step_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .page_ok (page_ok),
        .hits    (hits)
    );

    ulk_wc_timer #(.WC_CYCLES(WC_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (busy),
        .last  (tmr_last)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_en && hits.key_a) state_d = ST_STEP1;
            end
            ST_STEP1: begin
                if (wr_en) state_d = hits.key_b ? ST_STEP2 : ST_IDLE;
            end
            ST_STEP2: begin
                if (wr_en) state_d = hits.key_c ? ST_STEP3 : ST_IDLE;
            end
            ST_STEP3: begin
                if (wr_en) state_d = hits.key_a ? ST_STEP4 : ST_IDLE;
            end
            ST_STEP4: begin
                if (wr_en) begin
                    if (hits.sel_sfr)      state_d = ST_ARM_SFR;
                    else if (hits.sel_mem) state_d = ST_ARM_MEM;
                    else                   state_d = ST_IDLE;
                end
            end
            ST_ARM_SFR, ST_ARM_MEM: begin
                if (wr_en) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (tmr_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        take_value = wr_en && ((state_q == ST_ARM_SFR) || (state_q == ST_ARM_MEM));
        tmr_start  = take_value;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_sfr   <= 1'b0;
            ld_mem   <= 1'b0;
            ld_value <= '0;
        end else begin
            ld_sfr <= take_value && (state_q == ST_ARM_SFR);
            ld_mem <= take_value && (state_q == ST_ARM_MEM);
            if (take_value) ld_value <= wr_data;
        end
    end
endmodule

// File: rtl/ulk_seq_chk.sv
module ulk_seq_chk #(
    parameter int DATA_W    = 8,
    parameter int WC_CYCLES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              ld_sfr,
    input logic              ld_mem,
    input logic [DATA_W-1:0] ld_value,
    input logic              busy
);
    int   run_len;
    logic busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= 0;
            busy_q  <= 1'b0;
        end else begin
            run_len <= busy ? run_len + 1 : 0;
            busy_q  <= busy;
        end
    end

    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_sfr, ld_mem}));

    a_r6_sfr_single: assert property (@(posedge clk) disable iff (!rst_n)
        ld_sfr |=> !ld_sfr);

    a_r6_mem_single: assert property (@(posedge clk) disable iff (!rst_n)
        ld_mem |=> !ld_mem);

    a_r7_busy_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_sfr || ld_mem) |-> (busy && !busy_q));

    a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && busy_q) |-> (run_len == WC_CYCLES));

    a_r8_no_load_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !(ld_sfr || ld_mem));

    a_r5_value_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_sfr || ld_mem) |-> (ld_value == $past(wr_data) && $past(wr_en)));
endmodule

bind ulk_seq ulk_seq_chk #(.DATA_W(DATA_W), .WC_CYCLES(WC_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ld_sfr   (ld_sfr),
    .ld_mem   (ld_mem),
    .ld_value (ld_value),
    .busy     (busy)
);

// File: tb/sim_ulk_seq.sv
`timescale 1ns/1ps
module sim_ulk_seq;
    localparam int WC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [3:0]  wr_page = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  map_page = '0;
    logic        rd_plane = 1'b0;
    logic        ld_sfr, ld_mem, busy;
    logic [7:0]  ld_value;

    int n_run = 0;
    int n_fail = 0;
    int n_sfr = 0;
    int n_mem = 0;
    logic [7:0] seen_val;

    always #4 clk = ~clk;

    ulk_seq #(.WC_CYCLES(WC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_page(wr_page), .wr_data(wr_data), .map_page(map_page),
        .rd_plane(rd_plane), .ld_sfr(ld_sfr), .ld_mem(ld_mem),
        .ld_value(ld_value), .busy(busy)
    );

    always @(negedge clk) begin
        if (ld_sfr) begin n_sfr++; seen_val = ld_value; end
        if (ld_mem) begin n_mem++; seen_val = ld_value; end
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] good_page();
        return {map_page, ~rd_plane};
    endfunction

    task automatic wr(input logic [11:0] a, input logic [7:0] d, input logic [3:0] p);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_page = p;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 12'h123; wr_data = 8'h3C; wr_page = ~p;
    endtask

    // bad_step: 0..4 corrupts that command write, 5 = none
    task automatic seq(input logic [7:0] sel, input logic [7:0] val,
                       input logic [3:0] p, input int bad_step);
        logic [11:0] a [5];
        logic [7:0]  d [5];
        a[0] = 12'h555; d[0] = 8'hAA;
        a[1] = 12'hAAA; d[1] = 8'h55;
        a[2] = 12'h555; d[2] = 8'hA0;
        a[3] = 12'h555; d[3] = 8'hAA;
        a[4] = 12'h555; d[4] = sel;
        for (int i = 0; i < 5; i++) begin
            if (i == bad_step) wr(a[i], d[i] ^ 8'h01, p);
            else               wr(a[i], d[i], p);
        end
        wr(12'hF0F, val, ~p);
    endtask

    task automatic drain();
        repeat (WC + 3) @(negedge clk);
    endtask

    int s0, m0, blen;

    initial begin
        #1;
        check("R1 ld_sfr reset", ld_sfr, 0);
        check("R1 ld_mem reset", ld_mem, 0);
        check("R1 busy reset", busy, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after release", busy, 0);

        // R9: idle bus activity with wr_en low
        wr_addr = 12'h555; wr_data = 8'hAA; wr_page = good_page();
        repeat (4) @(negedge clk);
        wr(12'h555, 8'h11, good_page());
        s0 = n_sfr; m0 = n_mem;
        wr(12'hAAA, 8'h55, good_page());
        wr(12'h555, 8'hA0, good_page());
        wr(12'h555, 8'hAA, good_page());
        wr(12'h555, 8'hD0, good_page());
        wr(12'h000, 8'h77, good_page());
        drain();
        check("R9 no load without strobed opener", n_sfr + n_mem - s0 - m0, 0);

        // R2/R5/R6/R7: sweep all page configs and both selectors
        for (int mp = 0; mp < 8; mp++) begin
            for (int rp = 0; rp < 2; rp++) begin
                for (int k = 0; k < 2; k++) begin
                    logic [7:0] v;
                    map_page = 3'(mp); rd_plane = 1'(rp);
                    v = 8'(mp * 29 + rp * 7 + k * 101 + 3);
                    s0 = n_sfr; m0 = n_mem;
                    seq(k == 0 ? 8'hD0 : 8'hE0, v, good_page(), 5);
                    check("R7 busy in cycle of strobe", busy, 1);
                    check("R6 sfr strobe", ld_sfr, k == 0);
                    check("R6 mem strobe", ld_mem, k == 1);
                    check("R5 ld_value", ld_value, v);
                    blen = 0;
                    while (busy && blen < 1000) begin
                        blen++;
                        @(negedge clk);
                    end
                    check("R7 busy length", blen, WC);
                    check("R2 sfr load count", n_sfr - s0, k == 0);
                    check("R2 mem load count", n_mem - m0, k == 1);
                end
            end
        end

        // R3: every page value for the command writes
        map_page = 3'd5; rd_plane = 1'b1;
        for (int pg = 0; pg < 16; pg++) begin
            s0 = n_sfr;
            seq(8'hD0, 8'h5A, 4'(pg), 5);
            drain();
            check("R3 page gate", n_sfr - s0, (4'(pg) == 4'b1010) ? 1 : 0);
        end

        // R4: corrupt each step, then recover
        map_page = 3'd2; rd_plane = 1'b0;
        for (int st = 0; st < 5; st++) begin
            s0 = n_sfr; m0 = n_mem;
            seq(8'hE0, 8'h99, good_page(), st);
            drain();
            check("R4 aborted no load", n_sfr + n_mem - s0 - m0, 0);
            seq(8'hE0, 8'h42, good_page(), 5);
            drain();
            check("R4 recovery load", n_mem - m0, 1);
            check("R4 recovery value", seen_val, 8'h42);
        end
        // R4: wrong offset on step 2
        s0 = n_sfr;
        wr(12'h555, 8'hAA, good_page());
        wr(12'h555, 8'h55, good_page());
        wr(12'h555, 8'hA0, good_page());
        wr(12'h555, 8'hAA, good_page());
        wr(12'h555, 8'hD0, good_page());
        wr(12'h000, 8'h01, good_page());
        drain();
        check("R4 wrong offset no load", n_sfr - s0, 0);

        // R8: full sequence while busy is ignored
        s0 = n_sfr; m0 = n_mem;
        seq(8'hD0, 8'h10, good_page(), 5);
        wr(12'h555, 8'hAA, good_page());
        wr(12'hAAA, 8'h55, good_page());
        wr(12'h555, 8'hA0, good_page());
        wr(12'h555, 8'hAA, good_page());
        check("R8 still busy", busy, 1);
        wr(12'h555, 8'hE0, good_page());
        wr(12'h000, 8'h20, good_page());
        drain();
        check("R8 only first loads sfr", n_sfr - s0, 1);
        check("R8 busy write no mem load", n_mem - m0, 0);
        check("R8 value kept", seen_val, 8'h10);
        seq(8'hE0, 8'h30, good_page(), 5);
        drain();
        check("R8 load after busy", n_mem - m0, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule